// File: doc/BRIEF.md
# Nearest-Level Sorting Modulator with One Modulated Cell

This block drives one arm of a multilevel converter built from series-connected capacitor cells. For each new operating point it takes an arm voltage reference, the mean cell voltage, the measured voltage of every cell and the direction of the arm current. It divides the reference by the mean cell voltage to get an insertion level with an integer part and a fractional part. It then ranks the cells by voltage, so that the cells that most need to be used come first. The output is one insert bit per cell, and it stays in force for a fixed period of clock cycles that repeats until the next operating point is applied.

Two modes are supported. In plain mode the level is rounded to the nearest integer, and that many cells from the top of the ranking are inserted for the whole period. In modulated mode the integer number of cells is inserted for the whole period. The next cell in the ranking is inserted for the first part of each period, in proportion to the fraction, so that the arm voltage averaged over the period follows the reference. The level is always clamped to at most the number of cells, so the arm shows at most n+1 distinct voltage levels.

An operating point enters through a valid/ready handshake. `smp_ready` is high only while the block is idle. A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high. The source must hold its sample until that edge. While the block is computing, `smp_ready` stays low and any offered sample is left waiting; it is not dropped. The outputs are plain levels with no handshake, and `busy` marks the computation window.

Top module: `nls_modulator`

## Requirements
- R1: `smp_ready` is high exactly when `busy` is low. A sample is accepted on an edge with `smp_valid` and `smp_ready` both high, and `busy` is high in the following cycle. A sample offered while `busy` is high is not taken and has no effect on the result.
- R2: After an accepted sample, `busy` stays high for exactly VW+FRAC_W+(N_CELLS-1)^2+2 clock cycles (35 with default parameters). The new insert pattern takes effect on the edge where `busy` falls.
- R3: The level is floor(arm_ref·2^FRAC_W / cell_avg), split into an integer count and a FRAC_W-bit fraction. If the integer count is N_CELLS or more, or if cell_avg is zero, the count becomes N_CELLS and the fraction becomes 0.
- R4: With pwm_mode=0, the count is rounded to the nearest integer, with a fraction of exactly one half rounding up. The insert pattern then stays constant for the whole time it is in force.
- R5: With chg_dir=0 (current discharges the cells), cells are ranked from highest voltage to lowest. Cells with equal voltage are ranked lower index first. The cell voltage for cell i is `cell_v[i*VW +: VW]`, and insert bit i drives cell i.
- R6: With chg_dir=1 (current charges the cells), cells are ranked from lowest voltage to highest. Cells with equal voltage are ranked lower index first.
- R7: With pwm_mode=1 and an integer count k below N_CELLS, the k top-ranked cells are inserted throughout. The cell at rank k is inserted during the first (fraction·PERIOD)>>FRAC_W cycles of each PERIOD-cycle window, counted from the edge where `busy` falls. The pattern repeats every PERIOD cycles.
- R8: With pwm_mode=1, no cell is modulated when the count is clamped to N_CELLS or when the computed on-time is zero; only the fully inserted cells are on.
- R9: After reset all insert bits are 0, `busy` is 0 and `smp_ready` is 1.
- R10: While `busy` is high, the insert pattern of the previous operating point stays in force unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Operating-point sample offered |
| smp_ready | output | 1 | Block can take a sample |
| arm_ref | input | VW | Arm voltage reference, unsigned |
| cell_avg | input | VW | Mean cell capacitor voltage, unsigned |
| cell_v | input | N_CELLS*VW | Cell voltages, cell i at bits i*VW +: VW |
| chg_dir | input | 1 | 1: arm current charges cells, 0: discharges |
| pwm_mode | input | 1 | 1: modulated mode, 0: plain nearest-level mode |
| busy | output | 1 | Level and ranking computation in progress |
| insert | output | N_CELLS | Insert command per cell, bit i for cell i |

## Verification
The block is driven with references that produce fractions below one half, exactly one half and above one half. Comparing plain and modulated modes on these shows the difference between rounding up, rounding down and carrying the remainder on a single modulated cell. Distinct cell voltages and all-equal cell voltages are each tried under both current directions, which shows whether the ranking direction and the tie-break by index are correct. Over-range references, a zero mean voltage, a zero reference and an exact integer level exercise the clamp and the no-modulation path. A sample offered during the computation window shows that back-pressure holds and does not corrupt the result.

// File: rtl/nls_pkg.sv
package nls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_SORT = 2'd2
  } nls_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/nls_divider.sv
// Restoring divider: quo = floor(num * 2^FW / den), one quotient bit per cycle.
module nls_divider #(
  parameter int VW = 16,
  parameter int FW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VW-1:0]      num,
  input  logic [VW-1:0]      den,
  output logic               done,
  output logic [VW+FW-1:0]   quo
);
  localparam int DW = VW + FW;
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dvd_q;
  logic [DW-1:0] quo_q;
  logic [VW-1:0] rem_q;
  logic [VW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;

  logic [VW:0]   rem_sh;
  logic [VW:0]   diff;
  logic          ge;

  assign rem_sh = {rem_q, dvd_q[DW-1]};
  assign ge     = rem_sh >= {1'b0, dvs_q};
  assign diff   = rem_sh - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        dvd_q <= {num, {FW{1'b0}}};
        dvs_q <= den;
        rem_q <= '0;
        quo_q <= '0;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[VW-1:0] : rem_sh[VW-1:0];
        quo_q <= {quo_q[DW-2:0], ge};
        dvd_q <= {dvd_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

endmodule

// File: rtl/nls_ranker.sv
// Sequential compare-and-swap ranking, (N-1)^2 steps, stable on ties.
module nls_ranker #(
  parameter int N_CELLS = 4,
  parameter int VW      = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       start,
  input  logic                                       charge,
  input  logic [N_CELLS*VW-1:0]                      volts,
  output logic                                       done,
  output logic [N_CELLS*nls_pkg::idx_bits(N_CELLS)-1:0] order,
  output logic [N_CELLS*VW-1:0]                      sorted
);
  localparam int IW = nls_pkg::idx_bits(N_CELLS);

  logic [IW-1:0] idx_q [N_CELLS];
  logic [VW-1:0] vs_q  [N_CELLS];
  logic [IW-1:0] j_q;
  logic [IW-1:0] p_q;
  logic [IW-1:0] jn;
  logic          chg_q;
  logic          run_q;
  logic          done_q;
  logic [VW-1:0] va;
  logic [VW-1:0] vb;
  logic          swap;

  assign jn   = j_q + 1'b1;
  assign va   = vs_q[j_q];
  assign vb   = vs_q[jn];
  // charging: lowest first; discharging: highest first
  assign swap = chg_q ? (va > vb) : (va < vb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CELLS; i++) begin
        idx_q[i] <= IW'(i);
        vs_q[i]  <= '0;
      end
      j_q    <= '0;
      p_q    <= '0;
      chg_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        for (int i = 0; i < N_CELLS; i++) begin
          idx_q[i] <= IW'(i);
          vs_q[i]  <= volts[i*VW +: VW];
        end
        j_q   <= '0;
        p_q   <= '0;
        chg_q <= charge;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (swap) begin
          idx_q[j_q] <= idx_q[jn];
          idx_q[jn]  <= idx_q[j_q];
          vs_q[j_q]  <= vb;
          vs_q[jn]   <= va;
        end
        if (j_q == IW'(N_CELLS - 2)) begin
          j_q <= '0;
          if (p_q == IW'(N_CELLS - 2)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            p_q <= p_q + 1'b1;
          end
        end else begin
          j_q <= jn;
        end
      end
    end
  end

  for (genvar g = 0; g < N_CELLS; g++) begin : g_out
    assign order[g*IW +: IW]  = idx_q[g];
    assign sorted[g*VW +: VW] = vs_q[g];
  end

  assign done = done_q;

endmodule

// File: rtl/nls_cell_gate.sv
// Holds the applied pattern and the period counter; maps ranks to cell insert bits.
module nls_cell_gate #(
  parameter int N_CELLS = 4,
  parameter int PERIOD  = 16
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          load,
  input  logic [$clog2(N_CELLS+1)-1:0]                  lvl_in,
  input  logic [$clog2(PERIOD)-1:0]                     duty_in,
  input  logic                                          pwm_in,
  input  logic [N_CELLS*nls_pkg::idx_bits(N_CELLS)-1:0] order_in,
  output logic [N_CELLS-1:0]                            insert,
  output logic [$clog2(N_CELLS+1)-1:0]                  lvl_o,
  output logic                                          pwm_o
);
  localparam int IW  = nls_pkg::idx_bits(N_CELLS);
  localparam int LW  = $clog2(N_CELLS + 1);
  localparam int PCW = $clog2(PERIOD);

  logic [IW-1:0]      order_q [N_CELLS];
  logic [LW-1:0]      lvl_q;
  logic [PCW-1:0]     duty_q;
  logic [PCW-1:0]     pcnt_q;
  logic               pwm_q;
  logic [N_CELLS-1:0] rank_on;
  logic [N_CELLS-1:0] ins;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CELLS; i++) order_q[i] <= IW'(i);
      lvl_q  <= '0;
      duty_q <= '0;
      pcnt_q <= '0;
      pwm_q  <= 1'b0;
    end else if (load) begin
      for (int i = 0; i < N_CELLS; i++) order_q[i] <= order_in[i*IW +: IW];
      lvl_q  <= lvl_in;
      duty_q <= duty_in;
      pwm_q  <= pwm_in;
      pcnt_q <= '0;
    end else if (pcnt_q == PCW'(PERIOD - 1)) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  for (genvar r = 0; r < N_CELLS; r++) begin : g_rank
    assign rank_on[r] = (LW'(r) < lvl_q) ||
                        (pwm_q && (LW'(r) == lvl_q) && (pcnt_q < duty_q));
  end

  always_comb begin
    ins = '0;
    for (int r = 0; r < N_CELLS; r++) begin
      ins[order_q[r]] = ins[order_q[r]] | rank_on[r];
    end
  end

  assign insert = ins;
  assign lvl_o  = lvl_q;
  assign pwm_o  = pwm_q;

endmodule

// File: rtl/nls_modulator.sv
module nls_modulator #(
  parameter int N_CELLS = 4,
  parameter int VW      = 16,
  parameter int FRAC_W  = 8,
  parameter int PERIOD  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [VW-1:0]           arm_ref,
  input  logic [VW-1:0]           cell_avg,
  input  logic [N_CELLS*VW-1:0]   cell_v,
  input  logic                    chg_dir,
  input  logic                    pwm_mode,
  output logic                    busy,
  output logic [N_CELLS-1:0]      insert
);
  import nls_pkg::*;

  localparam int IW  = idx_bits(N_CELLS);
  localparam int LW  = $clog2(N_CELLS + 1);
  localparam int PCW = $clog2(PERIOD);
  localparam int DW  = VW + FRAC_W;
  localparam int PW  = FRAC_W + PCW + 1;

  nls_state_e            state_q;
  logic [N_CELLS*VW-1:0] cellv_q;
  logic                  chg_q;
  logic                  mode_q;

  logic                  accept;
  logic                  div_done;
  logic [DW-1:0]         div_quo;
  logic                  rk_start;
  logic                  rk_done;
  logic [N_CELLS*IW-1:0] rk_order;
  logic [N_CELLS*VW-1:0] rk_vs;
  logic                  apply;

  logic                  sat;
  logic [LW-1:0]         base_k;
  logic [FRAC_W-1:0]     frac_c;
  logic [PCW-1:0]        duty_c;
  logic [LW-1:0]         lvl_n;
  logic [PCW-1:0]        duty_n;
  logic [LW-1:0]         lvl_q;
  logic                  pwm_q;

  assign smp_ready = (state_q == ST_IDLE);
  assign busy      = !smp_ready;
  assign accept    = smp_valid && smp_ready;
  assign rk_start  = (state_q == ST_DIV) && div_done;
  assign apply     = (state_q == ST_SORT) && rk_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cellv_q <= '0;
      chg_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cellv_q <= cell_v;
          chg_q   <= chg_dir;
          mode_q  <= pwm_mode;
          state_q <= ST_DIV;
        end
        ST_DIV:  if (div_done) state_q <= ST_SORT;
        ST_SORT: if (rk_done)  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nls_divider #(.VW(VW), .FW(FRAC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .num   (arm_ref),
    .den   (cell_avg),
    .done  (div_done),
    .quo   (div_quo)
  );

  nls_ranker #(.N_CELLS(N_CELLS), .VW(VW)) u_rank (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rk_start),
    .charge (chg_q),
    .volts  (cellv_q),
    .done   (rk_done),
    .order  (rk_order),
    .sorted (rk_vs)
  );

  // Level split and clamp
  assign sat    = div_quo[DW-1:FRAC_W] >= VW'(N_CELLS);
  assign base_k = sat ? LW'(N_CELLS) : LW'(div_quo[DW-1:FRAC_W]);
  assign frac_c = sat ? '0 : div_quo[FRAC_W-1:0];
  assign duty_c = PCW'((PW'(frac_c) * PW'(PERIOD)) >> FRAC_W);

  always_comb begin
    if (mode_q) begin
      lvl_n  = base_k;
      duty_n = duty_c;
    end else begin
      lvl_n  = base_k + LW'(frac_c[FRAC_W-1]);
      duty_n = '0;
    end
  end

  nls_cell_gate #(.N_CELLS(N_CELLS), .PERIOD(PERIOD)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (apply),
    .lvl_in   (lvl_n),
    .duty_in  (duty_n),
    .pwm_in   (mode_q),
    .order_in (rk_order),
    .insert   (insert),
    .lvl_o    (lvl_q),
    .pwm_o    (pwm_q)
  );

endmodule

// File: rtl/nls_modulator_chk.sv
module nls_modulator_chk #(
  parameter int N_CELLS = 4,
  parameter int VW      = 16,
  parameter int FRAC_W  = 8,
  parameter int LW      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  smp_valid,
  input logic                  smp_ready,
  input logic                  busy,
  input logic [N_CELLS-1:0]    insert,
  input logic [LW-1:0]         lvl_q,
  input logic                  pwm_q,
  input logic                  apply,
  input logic                  rk_done,
  input logic                  rk_chg,
  input logic [N_CELLS*VW-1:0] rk_vs
);
  localparam int LAT = VW + FRAC_W + (N_CELLS - 1) * (N_CELLS - 1) + 2;

  int blen;

  always_ff @(posedge clk) begin
    if (!rst_n)    blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> busy);

  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (blen < LAT));

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == LAT));

  assert_plain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_q && !apply) |=> $stable(insert));

  assert_level_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(insert) == 32'(lvl_q)) || ($countones(insert) == 32'(lvl_q) + 1));

  for (genvar i = 0; i < N_CELLS - 1; i++) begin : g_rank_chk
    assert_rank_disch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rk_done && !rk_chg) |-> (rk_vs[i*VW +: VW] >= rk_vs[(i+1)*VW +: VW]));
    assert_rank_chg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rk_done && rk_chg) |-> (rk_vs[i*VW +: VW] <= rk_vs[(i+1)*VW +: VW]));
  end

endmodule

bind nls_modulator nls_modulator_chk #(
  .N_CELLS (N_CELLS),
  .VW      (VW),
  .FRAC_W  (FRAC_W),
  .LW      (LW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .busy      (busy),
  .insert    (insert),
  .lvl_q     (lvl_q),
  .pwm_q     (pwm_q),
  .apply     (apply),
  .rk_done   (rk_done),
  .rk_chg    (chg_q),
  .rk_vs     (rk_vs)
);

// File: tb/nls_modulator_bench.sv
`timescale 1ns/1ps
module nls_modulator_bench;
  localparam int N   = 4;
  localparam int VW  = 16;
  localparam int FW  = 8;
  localparam int PER = 16;
  localparam int LAT = VW + FW + (N - 1) * (N - 1) + 2;

  typedef struct packed {
    logic [N-1:0] full;
    logic [N-1:0] pwmc;
    logic [7:0]   duty;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            smp_valid = 1'b0;
  logic            smp_ready;
  logic [VW-1:0]   arm_ref = '0;
  logic [VW-1:0]   cell_avg = '0;
  logic [N*VW-1:0] cell_v = '0;
  logic            chg_dir = 1'b0;
  logic            pwm_mode = 1'b0;
  logic            busy;
  logic [N-1:0]    insert;

  int n_chk = 0;
  int n_bad = 0;
  int mon_done = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic         last_plain = 1'b1;
  logic [N-1:0] last_full = '0;

  always #4 clk = ~clk;

  nls_modulator #(.N_CELLS(N), .VW(VW), .FRAC_W(FW), .PERIOD(PER)) u_nls_modulator (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .arm_ref(arm_ref), .cell_avg(cell_avg), .cell_v(cell_v), .chg_dir(chg_dir),
    .pwm_mode(pwm_mode), .busy(busy), .insert(insert)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model(input int rf, input int av, input int v[N], input bit chg,
                       input bit md, output exp_t e);
    longint q;
    int k, fr, du, rank;
    if (av == 0) q = 64'h7fff_ffff;
    else         q = (longint'(rf) * 256) / av;
    k  = int'(q >> 8);
    fr = int'(q & 255);
    if (k >= N) begin k = N; fr = 0; end
    if (!md) begin
      if (fr >= 128) k++;
      du = 0;
    end else begin
      du = (fr * PER) >> 8;
    end
    e = '0;
    e.duty = du[7:0];
    for (int i = 0; i < N; i++) begin
      rank = 0;
      for (int j = 0; j < N; j++) begin
        if (j != i && ((chg ? (v[j] < v[i]) : (v[j] > v[i])) || (v[j] == v[i] && j < i)))
          rank++;
      end
      if (rank < k) e.full[i] = 1'b1;
      else if (rank == k && md && du > 0) e.pwmc[i] = 1'b1;
    end
  endtask

  // Driver: pushes expectations, drives one sample, watches the busy window.
  task automatic run(input int rf, input int av, input int v[N], input bit chg,
                     input bit md, input string tag, input bit bp);
    exp_t e;
    int   blen;
    int   start;
    model(rf, av, v, chg, md, e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    start = mon_done;
    @(negedge clk);
    check(smp_ready == 1'b1 && busy == 1'b0, "R1 ready while idle", int'(smp_ready), 1);
    smp_valid = 1'b1;
    arm_ref   = rf[VW-1:0];
    cell_avg  = av[VW-1:0];
    for (int i = 0; i < N; i++) cell_v[i*VW +: VW] = v[i][VW-1:0];
    chg_dir  = chg;
    pwm_mode = md;
    @(negedge clk);
    smp_valid = 1'b0;
    check(busy && !smp_ready, "R1 busy after accept", int'({busy, smp_ready}), 2);
    blen = 1;
    forever begin
      if (last_plain) check(insert == last_full, "R10 old pattern held while busy",
                            int'(insert), int'(last_full));
      if (bp && blen == 5) begin
        smp_valid = 1'b1;
        arm_ref   = 16'hffff;
        cell_avg  = 16'd1;
        pwm_mode  = ~md;
        chg_dir   = ~chg;
      end
      if (bp && blen == 10) begin
        check(!smp_ready, "R1 back-pressure while busy", int'(smp_ready), 0);
        smp_valid = 1'b0;
      end
      @(negedge clk);
      if (!busy) break;
      blen++;
    end
    check(blen == LAT, "R2 busy window length", blen, LAT);
    wait (mon_done != start);
    last_plain = !md;
    last_full  = e.full;
  endtask

  // Monitor: on each busy fall, pops one expectation and checks two periods.
  initial begin
    exp_t  e;
    string tg;
    logic  prev_busy;
    logic [N-1:0] expv;
    prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_busy && !busy && exp_q.size() > 0) begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        for (int t = 0; t < 2 * PER; t++) begin
          if (t > 0) @(negedge clk);
          expv = e.full | (((t % PER) < int'(e.duty)) ? e.pwmc : '0);
          check(insert == expv, tg, int'(insert), int'(expv));
        end
        mon_done++;
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog expired: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int va[N];
    int ve[N];
    va = '{1010, 990, 1030, 1000};
    ve = '{1000, 1000, 1000, 1000};
    repeat (3) @(negedge clk);
    check(insert == '0, "R9 insert cleared in reset", int'(insert), 0);
    check(!busy && smp_ready, "R9 idle in reset", int'({busy, smp_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(insert == '0 && !busy && smp_ready, "R9 idle after reset",
          int'({insert, busy, smp_ready}), 1);

    run(2600, 1000, va, 1'b0, 1'b0, "R4 R5 plain round up, discharge", 1'b0);
    run(2400, 1000, va, 1'b0, 1'b0, "R4 plain round down", 1'b0);
    run(2600, 1000, va, 1'b1, 1'b1, "R6 R7 modulated, charge", 1'b0);
    run(1300, 1000, va, 1'b0, 1'b1, "R5 R7 modulated, low level", 1'b0);
    run(3999, 1000, va, 1'b0, 1'b1, "R7 modulated, near-full on-time", 1'b0);
    run(2000, 1000, ve, 1'b0, 1'b0, "R5 equal voltages, index order", 1'b0);
    run(1000, 1000, ve, 1'b1, 1'b0, "R6 equal voltages, charge", 1'b0);
    run(9000, 1000, va, 1'b0, 1'b1, "R3 R8 clamp above cell count", 1'b0);
    run(500, 0, va, 1'b1, 1'b1, "R3 zero mean voltage clamps", 1'b0);
    run(0, 1000, va, 1'b0, 1'b0, "R3 zero reference", 1'b0);
    run(1500, 1000, va, 1'b0, 1'b0, "R1 R4 half rounds up under back-pressure", 1'b1);
    run(2000, 1000, va, 1'b1, 1'b1, "R8 exact level, no modulated cell", 1'b0);
    run(2200, 1000, va, 1'b0, 1'b1, "R7 modulated after plain", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule